// File: doc/BRIEF.md
# Data-Processing ALU with Flag Logic

This block is the arithmetic and logic stage of a 32-bit processor datapath. It takes the first source operand and an already shifted second operand, together with a 4-bit operation code, and produces the operation result in the same cycle. It also produces a write enable for the destination register and the next values of the four condition flags: negative, zero, carry and overflow. The register file, the barrel shifter and the multiplier sit outside it. The shifter hands in its carry-out for the logical operations to use.

The datapath is purely combinational: there is no clock, no reset and no handshake. The surrounding pipeline stage registers the outputs.

Flag updates follow the processor's conventions. After a subtraction the carry flag means "no borrow". Logical operations take their carry from the shifter and keep the overflow flag. The four compare and test operations only set flags and never write a register. A flag-setting operation that targets the program counter, while the core is in a mode that owns a saved status register, does not touch the flags. Instead it raises a request for the status logic to copy the saved status back into the current one.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic operations by code: SUB 0010 = Rn-op2, RSB 0011 = op2-Rn, ADD 0100 = Rn+op2, ADC 0101 = Rn+op2+C, SBC 0110 = Rn-op2-(1-C), RSC 0111 = op2-Rn-(1-C), CMP 1010 as SUB, CMN 1011 as ADD. The result is taken modulo 2^32.
- R2: Logical operations by code: AND 0000, EOR 0001, TST 1000 (as AND), TEQ 1001 (as EOR), ORR 1100, MOV 1101 = op2, BIC 1110 = Rn AND NOT op2, MVN 1111 = NOT op2.
- R3: When flags are updated by an addition (ADD, ADC, CMN), C is the unsigned carry out of bit 31 and V is the signed overflow.
- R4: When flags are updated by a subtraction (SUB, RSB, SBC, RSC, CMP), C is 1 exactly when no borrow occurs, and V is the signed overflow.
- R5: When flags are updated by a logical operation, C equals shift_carry and V keeps flag_v_in.
- R6: For TST, TEQ, CMP and CMN (codes 10xx), dest_we is 0, and the flags are updated whatever the value of set_flags.
- R7: For the other twelve codes, dest_we is 1.
- R8: For a code outside 10xx with set_flags at 0, all four flag outputs equal the flag inputs.
- R9: When flags would be updated and both dest_is_pc and mode_has_saved are 1, restore_req is 1 and the four flag outputs equal the flag inputs. In every other case restore_req is 0. The result and dest_we are not affected.
- R10: Whenever flags are updated, N equals result bit 31 and Z is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation code (see R1, R2) |
| rn_val | input | 32 | First source operand |
| op2_val | input | 32 | Shifted second operand |
| set_flags | input | 1 | Request a flag update |
| shift_carry | input | 1 | Carry-out from the shifter |
| flag_n_in | input | 1 | Current negative flag |
| flag_z_in | input | 1 | Current zero flag |
| flag_c_in | input | 1 | Current carry flag |
| flag_v_in | input | 1 | Current overflow flag |
| dest_is_pc | input | 1 | Destination is the program counter |
| mode_has_saved | input | 1 | Current mode owns a saved status register |
| result | output | 32 | Operation result |
| dest_we | output | 1 | Write the destination register |
| flag_n_out | output | 1 | Next negative flag |
| flag_z_out | output | 1 | Next zero flag |
| flag_c_out | output | 1 | Next carry flag |
| flag_v_out | output | 1 | Next overflow flag |
| restore_req | output | 1 | Copy the saved status back instead of updating flags |

## Verification
Every code is applied to a grid of operands that includes 0, 1, all-ones, 0x7FFFFFFF and 0x80000000, with carry-in 0 and 1 and with set_flags both clear and set. This grid separates a carry taken from the adder from one taken from the shifter, a true borrow from an inverted one, and signed overflow from unsigned carry. A table of directed vectors targets the overflow edges and equal operands, where a compare must set Z and C together. Separate cases apply every combination of dest_is_pc and mode_has_saved to show that the restore request replaces the flag update only when all its conditions hold, including for compare operations with set_flags clear.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [2:0] {
    LF_AND, LF_EOR, LF_ORR, LF_PASS, LF_CLR, LF_NOT
  } logic_fn_e;

  typedef enum logic [1:0] {
    CI_ZERO, CI_ONE, CI_FLAG
  } cin_sel_e;

  typedef struct packed {
    logic      is_arith;
    logic      swap;
    logic      invert_b;
    cin_sel_e  cin_sel;
    logic_fn_e lfn;
    logic      writes_dest;
  } op_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import dpalu_pkg::*;
(
  input  alu_op_e  op,
  output op_ctrl_t ctrl
);
  always_comb begin
    ctrl = '{is_arith: 1'b0, swap: 1'b0, invert_b: 1'b0,
             cin_sel: CI_ZERO, lfn: LF_AND, writes_dest: 1'b1};
    case (op)
      OP_AND: ctrl.lfn = LF_AND;
      OP_EOR: ctrl.lfn = LF_EOR;
      OP_ORR: ctrl.lfn = LF_ORR;
      OP_MOV: ctrl.lfn = LF_PASS;
      OP_BIC: ctrl.lfn = LF_CLR;
      OP_MVN: ctrl.lfn = LF_NOT;
      OP_TST: begin ctrl.lfn = LF_AND; ctrl.writes_dest = 1'b0; end
      OP_TEQ: begin ctrl.lfn = LF_EOR; ctrl.writes_dest = 1'b0; end
      OP_ADD: ctrl.is_arith = 1'b1;
      OP_ADC: begin ctrl.is_arith = 1'b1; ctrl.cin_sel = CI_FLAG; end
      OP_CMN: begin ctrl.is_arith = 1'b1; ctrl.writes_dest = 1'b0; end
      OP_SUB: begin
        ctrl.is_arith = 1'b1; ctrl.invert_b = 1'b1; ctrl.cin_sel = CI_ONE;
      end
      OP_CMP: begin
        ctrl.is_arith = 1'b1; ctrl.invert_b = 1'b1; ctrl.cin_sel = CI_ONE;
        ctrl.writes_dest = 1'b0;
      end
      OP_RSB: begin
        ctrl.is_arith = 1'b1; ctrl.swap = 1'b1; ctrl.invert_b = 1'b1;
        ctrl.cin_sel = CI_ONE;
      end
      OP_SBC: begin
        ctrl.is_arith = 1'b1; ctrl.invert_b = 1'b1; ctrl.cin_sel = CI_FLAG;
      end
      OP_RSC: begin
        ctrl.is_arith = 1'b1; ctrl.swap = 1'b1; ctrl.invert_b = 1'b1;
        ctrl.cin_sel = CI_FLAG;
      end
      default: ctrl.lfn = LF_AND;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rn,
  input  logic [DW-1:0] op2,
  input  logic          swap,
  input  logic          invert_b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] x, y_raw, y;
  logic [DW:0]   full;

  always_comb begin
    x     = swap ? op2 : rn;
    y_raw = swap ? rn  : op2;
    y     = invert_b ? ~y_raw : y_raw;
    full  = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
    sum   = full[DW-1:0];
    cout  = full[DW];
    ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end

  // Carry out means the sum wrapped below the first addend (R3, R4)
  always_comb begin
    if (cout === 1'b1)
      a_r3_carry_wraps: assert (sum <= x) else $error("carry without wrap");
    if (cout === 1'b0)
      a_r4_nocarry_grows: assert (sum >= x) else $error("wrap without carry");
    if (ovf === 1'b1)
      a_r3_ovf_same_sign: assert (x[MSB] == y[MSB]) else $error("overflow from mixed signs");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import dpalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rn,
  input  logic [DW-1:0] op2,
  input  logic_fn_e     fn,
  output logic [DW-1:0] res
);
  always_comb begin
    case (fn)
      LF_AND:  res = rn & op2;
      LF_EOR:  res = rn ^ op2;
      LF_ORR:  res = rn | op2;
      LF_PASS: res = op2;
      LF_CLR:  res = rn & ~op2;
      LF_NOT:  res = ~op2;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] res,
  input  logic          is_arith,
  input  logic          add_c,
  input  logic          add_v,
  input  logic          shift_carry,
  input  logic          update,
  input  logic          dest_is_pc,
  input  logic          mode_has_saved,
  input  logic [3:0]    nzcv_in,
  output logic [3:0]    nzcv_out,
  output logic          restore_req
);
  logic [3:0] fresh;

  always_comb begin
    restore_req = update & dest_is_pc & mode_has_saved;
    fresh[3] = res[DW-1];
    fresh[2] = ~|res;
    fresh[1] = is_arith ? add_c : shift_carry;
    fresh[0] = is_arith ? add_v : nzcv_in[0];
    nzcv_out = (update && !restore_req) ? fresh : nzcv_in;
  end

  always_comb begin
    if (update === 1'b0)
      a_r8_hold_flags: assert (nzcv_out == nzcv_in) else $error("flags moved without update");
    if (restore_req === 1'b1)
      a_r9_restore_keeps: assert (nzcv_out == nzcv_in) else $error("flags moved during restore");
    if (restore_req === 1'b1)
      a_r9_restore_cause: assert (dest_is_pc && mode_has_saved) else $error("spurious restore");
    if (update === 1'b1 && is_arith === 1'b0)
      a_r5_logic_v_kept: assert (nzcv_out[0] == nzcv_in[0]) else $error("logical op changed V");
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    opcode,
  input  logic [DW-1:0] rn_val,
  input  logic [DW-1:0] op2_val,
  input  logic          set_flags,
  input  logic          shift_carry,
  input  logic          flag_n_in,
  input  logic          flag_z_in,
  input  logic          flag_c_in,
  input  logic          flag_v_in,
  input  logic          dest_is_pc,
  input  logic          mode_has_saved,
  output logic [DW-1:0] result,
  output logic          dest_we,
  output logic          flag_n_out,
  output logic          flag_z_out,
  output logic          flag_c_out,
  output logic          flag_v_out,
  output logic          restore_req
);
  op_ctrl_t      ctrl;
  logic [DW-1:0] sum, lres;
  logic          cout, ovf, cin, update;
  logic [3:0]    nzcv_out;

  alu_decode u_dec (.op(alu_op_e'(opcode)), .ctrl(ctrl));

  always_comb begin
    case (ctrl.cin_sel)
      CI_ONE:  cin = 1'b1;
      CI_FLAG: cin = flag_c_in;
      default: cin = 1'b0;
    endcase
  end

  alu_adder #(.DW(DW)) u_add (
    .rn(rn_val), .op2(op2_val), .swap(ctrl.swap), .invert_b(ctrl.invert_b),
    .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
  );

  alu_logic #(.DW(DW)) u_log (
    .rn(rn_val), .op2(op2_val), .fn(ctrl.lfn), .res(lres)
  );

  always_comb begin
    result  = ctrl.is_arith ? sum : lres;
    dest_we = ctrl.writes_dest;
    update  = set_flags | ~ctrl.writes_dest;
  end

  alu_flags #(.DW(DW)) u_flg (
    .res(result), .is_arith(ctrl.is_arith), .add_c(cout), .add_v(ovf),
    .shift_carry(shift_carry), .update(update), .dest_is_pc(dest_is_pc),
    .mode_has_saved(mode_has_saved),
    .nzcv_in({flag_n_in, flag_z_in, flag_c_in, flag_v_in}),
    .nzcv_out(nzcv_out), .restore_req(restore_req)
  );

  assign {flag_n_out, flag_z_out, flag_c_out, flag_v_out} = nzcv_out;

  always_comb begin
    if (opcode[3:2] === 2'b10)
      a_r6_compare_no_write: assert (!dest_we) else $error("compare wrote dest");
    if (opcode[3:2] !== 2'b10 && !$isunknown(opcode))
      a_r7_writes_dest: assert (dest_we) else $error("missing dest write");
    if (update === 1'b1 && restore_req === 1'b0)
      a_r10_zero_flag: assert (flag_z_out == (result == '0)) else $error("Z mismatch");
    if (update === 1'b1 && restore_req === 1'b0)
      a_r10_neg_flag: assert (flag_n_out == result[DW-1]) else $error("N mismatch");
  end
endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  opcode = '0;
  logic [31:0] rn_val = '0, op2_val = '0;
  logic set_flags = 0, shift_carry = 0, dest_is_pc = 0, mode_has_saved = 0;
  logic fn_i = 0, fz_i = 0, fc_i = 0, fv_i = 0;
  logic [31:0] result;
  logic dest_we, fn_o, fz_o, fc_o, fv_o, restore_req;

  int checks = 0, errors = 0;
  bit finished = 0;

  dp_alu dut (
    .opcode(opcode), .rn_val(rn_val), .op2_val(op2_val), .set_flags(set_flags),
    .shift_carry(shift_carry), .flag_n_in(fn_i), .flag_z_in(fz_i),
    .flag_c_in(fc_i), .flag_v_in(fv_i), .dest_is_pc(dest_is_pc),
    .mode_has_saved(mode_has_saved), .result(result), .dest_we(dest_we),
    .flag_n_out(fn_o), .flag_z_out(fz_o), .flag_c_out(fc_o), .flag_v_out(fv_o),
    .restore_req(restore_req)
  );

  // packed expectation: {result[31:0], we, n, z, c, v, restore}
  function automatic logic [37:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic setf, input logic sc, input logic [3:0] f,
      input logic pc, input logic sv);
    logic [63:0] ua, ub, ut;
    longint sa, sb, st;
    logic [31:0] r;
    logic arith, cmpop, cc, vv, upd, rst;
    logic [3:0] nf;
    ua = {32'b0, a}; ub = {32'b0, b};
    sa = longint'($signed(a)); sb = longint'($signed(b));
    arith = 1; cc = 0; ut = 0; st = 0; r = 0;
    cmpop = (op[3:2] == 2'b10);
    case (op)
      4'h0, 4'h8: begin arith = 0; r = a & b; end
      4'h1, 4'h9: begin arith = 0; r = a ^ b; end
      4'hC: begin arith = 0; r = a | b; end
      4'hD: begin arith = 0; r = b; end
      4'hE: begin arith = 0; r = a & ~b; end
      4'hF: begin arith = 0; r = ~b; end
      4'h4, 4'hB: begin ut = ua + ub; st = sa + sb; cc = ut[32]; end
      4'h5: begin ut = ua + ub + f[1]; st = sa + sb + f[1]; cc = ut[32]; end
      4'h2, 4'hA: begin ut = ua - ub; st = sa - sb; cc = (ua >= ub); end
      4'h3: begin ut = ub - ua; st = sb - sa; cc = (ub >= ua); end
      4'h6: begin ut = ua - ub - {63'b0, !f[1]}; st = sa - sb - (f[1] ? 0 : 1);
                  cc = (ua >= ub + {63'b0, !f[1]}); end
      default: begin ut = ub - ua - {63'b0, !f[1]}; st = sb - sa - (f[1] ? 0 : 1);
                  cc = (ub >= ua + {63'b0, !f[1]}); end
    endcase
    if (arith) begin
      r = ut[31:0];
      vv = (st > 64'sd2147483647) || (st < -64'sd2147483648);
    end else begin
      cc = sc; vv = f[0];
    end
    upd = setf | cmpop;
    rst = upd & pc & sv;
    nf = (upd && !rst) ? {r[31], r == 0, cc, vv} : f;
    return {r, !cmpop, nf, rst};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic setf, input logic sc, input logic [3:0] f, input logic pc, input logic sv);
    @(negedge clk);
    opcode = op; rn_val = a; op2_val = b; set_flags = setf; shift_carry = sc;
    {fn_i, fz_i, fc_i, fv_i} = f; dest_is_pc = pc; mode_has_saved = sv;
    #2;
  endtask

  function automatic logic [37:0] got();
    return {result, dest_we, fn_o, fz_o, fc_o, fv_o, restore_req};
  endfunction

  task automatic check(input string req, input logic [37:0] exp);
    checks++;
    if (got() !== exp) begin
      errors++;
      $display("FAIL %s op=%h rn=%h op2=%h: actual=%h expected=%h", req, opcode,
               rn_val, op2_val, got(), exp);
    end
  endtask

  task automatic run_model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic setf, input logic sc, input logic [3:0] f, input logic pc, input logic sv);
    apply(op, a, b, setf, sc, f, pc, sv);
    if (op[3:2] == 2'b10 || op[3:1] == 3'b000 || op[3:2] == 2'b11)
      check("R2 R5 R6 R7 R8 R10", model(op, a, b, setf, sc, f, pc, sv));
    else
      check("R1 R3 R4 R7 R8 R10", model(op, a, b, setf, sc, f, pc, sv));
  endtask

  // {op, rn, op2, carry_in, shift_carry}
  localparam logic [69:0] VEC [16] = '{
    {4'h4, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0},
    {4'h4, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1},
    {4'h5, 32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b0},
    {4'h5, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b0},
    {4'h2, 32'h80000000, 32'h00000001, 1'b0, 1'b0},
    {4'h2, 32'h00000000, 32'h00000001, 1'b1, 1'b1},
    {4'h3, 32'h00000001, 32'h80000000, 1'b0, 1'b0},
    {4'h6, 32'h00000005, 32'h00000005, 1'b0, 1'b0},
    {4'h6, 32'h00000005, 32'h00000005, 1'b1, 1'b0},
    {4'h7, 32'h00000000, 32'h00000000, 1'b0, 1'b1},
    {4'hA, 32'h12345678, 32'h12345678, 1'b0, 1'b0},
    {4'hB, 32'h80000000, 32'h80000000, 1'b0, 1'b0},
    {4'h0, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b0, 1'b1},
    {4'h9, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1, 1'b0},
    {4'hE, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 1'b1},
    {4'hF, 32'h00000000, 32'h00000000, 1'b1, 1'b0}
  };

  localparam logic [31:0] OPS [6] = '{32'h0, 32'h1, 32'hFFFFFFFF,
                                      32'h7FFFFFFF, 32'h80000000, 32'h5A5AA5A5};

  initial begin
    // R8: idle inputs, AND of zeros, no flag update
    #6;
    check("R8 idle", {32'h0, 1'b1, 4'b0000, 1'b0});

    // R1 R3 R4 R5: vector table
    for (int i = 0; i < 16; i++)
      run_model(VEC[i][69:66], VEC[i][65:34], VEC[i][33:2], 1'b1, VEC[i][0],
                {2'b00, VEC[i][1], i[0]}, 1'b0, 1'b0);

    // R1 R2: sweep of all codes over operand grid, carry and set-flags
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 4; k++)
            run_model(op[3:0], OPS[i], OPS[j], k[1], k[0] ^ j[0],
                      {k[0], 1'b0, k[0], ~k[0]}, 1'b0, 1'b0);

    // R3: ADD signed overflow boundary, explicit
    apply(4'h4, 32'h7FFFFFFF, 32'h1, 1, 0, 4'b0000, 0, 0);
    check("R3 add overflow", {32'h80000000, 1'b1, 4'b1001, 1'b0});
    // R4: SUB signed overflow with no borrow
    apply(4'h2, 32'h80000000, 32'h1, 1, 0, 4'b0000, 0, 0);
    check("R4 sub overflow", {32'h7FFFFFFF, 1'b1, 4'b0011, 1'b0});
    // R6: CMP equal with set_flags clear still sets Z and C, no write
    apply(4'hA, 32'h5, 32'h5, 0, 0, 4'b0000, 0, 0);
    check("R6 cmp", {32'h0, 1'b0, 4'b0110, 1'b0});
    // R5: MOV keeps V, takes shifter carry
    apply(4'hD, 32'h0, 32'h80000000, 1, 1, 4'b0001, 0, 0);
    check("R5 mov", {32'h80000000, 1'b1, 4'b1011, 1'b0});
    // R8: overflowing ADD without set_flags keeps flags
    apply(4'h4, 32'h7FFFFFFF, 32'h1, 0, 0, 4'b0110, 1, 1);
    check("R8 hold", {32'h80000000, 1'b1, 4'b0110, 1'b0});
    // R9: restore request combinations
    for (int m = 0; m < 4; m++) begin
      apply(4'h2, 32'h3, 32'h3, 1, 0, 4'b1001, m[1], m[0]);
      if (m == 3) check("R9 restore", {32'h0, 1'b1, 4'b1001, 1'b1});
      else        check("R9 no restore", {32'h0, 1'b1, 4'b0110, 1'b0});
    end
    apply(4'h8, 32'h0, 32'h0, 0, 1, 4'b0000, 1, 1);
    check("R9 R6 tst restore", {32'h0, 1'b0, 4'b0000, 1'b1});

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule